// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the registers of an Ethernet PHY through the two-wire serial management bus. The host sees two 16-bit registers. The control register holds a start/busy flag, a direction flag, a clock-range selector, the PHY address and the register address. The data register holds the value that goes out on a write and the value that comes back on a read.

Setting the busy flag in a control write starts one 64-bit management frame on MDC/MDIO. The busy flag reads back as one until the frame has finished. The clock-range selector sits in the same word that starts each frame, so software must write the same selector value again with every command.

For a write, the host loads the data register first and then issues the command. For a read, the block releases MDIO from the turnaround onward. It collects the PHY's reply, and the reply can be read from the data register once busy has cleared.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, both registers read zero, MDC is low and MDIO is released (output enable low).
- R2: A control write (select 0) with bit 0 set starts a frame. The bits of the control word are: bit 0 busy, bit 1 write (1) or read (0), bits 4:2 clock range, bits 9:5 PHY address, bits 14:10 register address, and bit 15, which always reads 0. Bit 0 reads 1 until the frame ends and reads 0 after it.
- R3: Each frame is 64 bit times, sent MSB first in every field. It starts with 32 ones and then the start pattern 01. Next comes an opcode of 01 for a write or 10 for a read, followed by the 5-bit PHY address and the 5-bit register address.
- R4: In a write frame, the turnaround is driven as 10 and is followed by the 16 bits of the data register. MDIO is driven for all 64 bit times.
- R5: In a read frame, MDIO is released from the first turnaround bit (bit 46) to the end of the frame. MDIO is sampled at each rising MDC during the last 16 bits, and the data register holds the sampled value once busy clears.
- R6: MDC is low for 2^range clock cycles and then high for 2^range cycles in every bit time. MDIO changes only while MDC is low, and MDC is low when a frame ends.
- R7: Control writes are ignored while busy is set.
- R8: Data register writes (select 1) are ignored while busy is set.
- R9: A control write with bit 0 clear stores the fields without starting a frame. While idle, MDC stays low and MDIO stays released.
- R10: A data write while idle sets the data register to that value, and a write frame leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| host_wdata | input | 16 | Register write value |
| ctrl_q | output | 16 | Control register read value |
| data_q | output | 16 | Data register read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A behavioural timeline model in the bench predicts MDC, the output enable, every driven MDIO bit and both register values on every cycle. It is run under three clock ranges, so that a wrong divider or a bit-boundary slip shows up as a timing mismatch.

Frames use PHY and register addresses of all zeros and all ones, and read replies with a single set MSB and LSB, so that field order, bit order and a shift of one bit can be told apart. A configuration-only write separates starting a frame from storing fields. Register writes issued in the middle of frames show whether the busy interlock holds for each register.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int PREAMBLE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_sel,
  input  logic [15:0] host_wdata,
  output logic [15:0] ctrl_q,
  output logic [15:0] data_q,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = PREAMBLE + 32;
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_BIT = CNT_W'(FRAME_LEN - 18);
  localparam logic [CNT_W-1:0] DATA_BIT = CNT_W'(FRAME_LEN - 16);

  logic                 busy_q, wr_q, mdc_q;
  logic [2:0]           rng_q;
  logic [4:0]           phy_q, reg_q;
  logic [15:0]          data_r;
  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     bit_q;
  logic [7:0]           hc_q;

  wire ctrl_wr = host_we && !host_sel && !busy_q;
  wire data_wr = host_we && host_sel && !busy_q;
  wire cmd_wr  = host_wdata[1];
  wire [7:0] half_m1  = (8'd1 << rng_q) - 8'd1;
  wire [7:0] start_m1 = (8'd1 << host_wdata[4:2]) - 8'd1;
  wire tick = busy_q && (hc_q == 8'd0);
  wire rise = tick && !mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      rng_q  <= '0;
      phy_q  <= '0;
      reg_q  <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
      hc_q   <= '0;
      mdc_q  <= 1'b0;
    end else if (ctrl_wr) begin
      busy_q <= host_wdata[0];
      wr_q   <= cmd_wr;
      rng_q  <= host_wdata[4:2];
      phy_q  <= host_wdata[9:5];
      reg_q  <= host_wdata[14:10];
      if (host_wdata[0]) begin
        sh_q  <= {{PREAMBLE{1'b1}}, 2'b01, cmd_wr ? 2'b01 : 2'b10,
                  host_wdata[9:5], host_wdata[14:10],
                  cmd_wr ? 2'b10 : 2'b00, cmd_wr ? data_r : 16'h0000};
        bit_q <= '0;
        hc_q  <= start_m1;
        mdc_q <= 1'b0;
      end
    end else if (busy_q) begin
      if (hc_q != 8'd0) begin
        hc_q <= hc_q - 8'd1;
      end else begin
        hc_q  <= half_m1;
        mdc_q <= !mdc_q;
        if (mdc_q) begin
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (bit_q == LAST_BIT) busy_q <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_r <= '0;
    else if (data_wr)
      data_r <= host_wdata;
    else if (rise && !wr_q && bit_q >= DATA_BIT)
      data_r <= {data_r[14:0], mdio_i};
  end

  assign ctrl_q  = {1'b0, reg_q, phy_q, rng_q, wr_q, busy_q};
  assign data_q  = data_r;
  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[FRAME_LEN-1];
  assign mdio_oe = busy_q && (wr_q || bit_q < TA_BIT);

  assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (!mdc && !mdio_oe));

  assert_oe_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && $past(ctrl_q[0])) |-> !$rose(mdio_oe));

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && host_we && !host_sel) |=> $stable(ctrl_q[15:1]));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_q) |=> $stable(data_q));

  assert_start_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[0]) |-> (mdio_oe && mdio_o && !mdc));

  assert_end_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[0]) |-> !mdc);

  assert_mdio_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] ctrl_q, data_q;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .ctrl_q(ctrl_q), .data_q(data_q),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  bit          m_busy = 0, m_wr = 0;
  int          m_k = 0, m_h = 1;
  logic [15:0] m_ctrl = '0, m_data = '0, rd_val = '0;
  logic [63:0] m_frame = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // behavioural model of the register file and frame timeline
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_ctrl = '0; m_data = '0;
    end else if (m_busy) begin
      m_k++;
      if (m_k == 128 * m_h) begin
        m_busy = 0;
        m_ctrl[0] = 1'b0;
        if (!m_wr) m_data = rd_val;
      end
    end else if (host_we) begin
      if (host_sel) m_data = host_wdata;
      else begin
        m_ctrl = {1'b0, host_wdata[14:0]};
        if (host_wdata[0]) begin
          m_busy = 1; m_k = 0;
          m_h = 1 << host_wdata[4:2];
          m_wr = host_wdata[1];
          m_frame = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10,
                     host_wdata[9:5], host_wdata[14:10],
                     m_wr ? 2'b10 : 2'b00, m_wr ? m_data : 16'h0000};
        end
      end
    end
  end

  // per-cycle comparison and PHY responder
  always @(negedge clk) begin
    if (rst_n) begin
      int b, ph;
      bit eoe, emdc;
      b = m_k / (2 * m_h);
      ph = (m_k / m_h) % 2;
      emdc = m_busy && (ph == 1);
      eoe = m_busy && (m_wr || b < 46);
      chk(mdc == emdc, "R6 mdc", int'(mdc), int'(emdc));
      chk(mdio_oe == eoe, m_wr ? "R4 oe" : "R5 oe", int'(mdio_oe), int'(eoe));
      if (eoe) chk(mdio_o == m_frame[63 - b], "R3 mdio bit", int'(mdio_o), int'(m_frame[63 - b]));
      chk(ctrl_q == m_ctrl, "R2/R7 ctrl", int'(ctrl_q), int'(m_ctrl));
      if (!(m_busy && !m_wr)) chk(data_q == m_data, "R8/R10 data", int'(data_q), int'(m_data));
      mdio_i = (m_busy && !m_wr && b >= 48) ? rd_val[15 - (b - 48)] : 1'b1;
    end
  end

  task automatic reg_wr(input bit sel, input logic [15:0] v);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  function automatic logic [15:0] cmd(input bit go, input bit wr, input int rng,
                                      input int phy, input int rg);
    return {1'b0, rg[4:0], phy[4:0], rng[2:0], wr, go};
  endfunction

  task automatic wait_idle();
    @(negedge clk);
    while (ctrl_q[0]) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(ctrl_q == 16'h0 && data_q == 16'h0, "R1 regs", int'({ctrl_q, data_q}), 0);
    chk(!mdc && !mdio_oe, "R1 pins", int'({mdc, mdio_oe}), 0);
    rst_n = 1'b1;

    reg_wr(1, 16'hA5C3);
    chk(data_q == 16'hA5C3, "R10 data write idle", int'(data_q), 16'hA5C3);
    reg_wr(0, cmd(0, 1, 1, 3, 7));
    repeat (20) @(negedge clk);
    chk(!mdc && !mdio_oe && ctrl_q == cmd(0, 1, 1, 3, 7), "R9 config only",
        int'(ctrl_q), int'(cmd(0, 1, 1, 3, 7)));

    reg_wr(0, cmd(1, 1, 0, 0, 31));
    chk(ctrl_q[0] == 1'b1, "R2 busy set", int'(ctrl_q[0]), 1);
    repeat (30) @(negedge clk);
    reg_wr(1, 16'h1234);
    wait_idle();
    chk(ctrl_q[0] == 1'b0, "R2 busy clear", int'(ctrl_q[0]), 0);
    chk(data_q == 16'hA5C3, "R8 R10 data kept", int'(data_q), 16'hA5C3);

    rd_val = 16'h8001;
    reg_wr(0, cmd(1, 0, 1, 31, 0));
    repeat (50) @(negedge clk);
    reg_wr(0, cmd(1, 1, 2, 5, 5));
    chk(ctrl_q == cmd(1, 0, 1, 31, 0), "R7 ctrl ignored", int'(ctrl_q), int'(cmd(1, 0, 1, 31, 0)));
    wait_idle();
    chk(data_q == 16'h8001, "R5 read value", int'(data_q), 16'h8001);

    rd_val = 16'h3C5A;
    reg_wr(0, cmd(1, 0, 2, 21, 10));
    wait_idle();
    chk(data_q == 16'h3C5A, "R5 read value rng2", int'(data_q), 16'h3C5A);

    reg_wr(1, 16'h0001);
    reg_wr(0, cmd(1, 1, 2, 31, 31));
    wait_idle();
    chk(data_q == 16'h0001, "R4 R10 write keeps data", int'(data_q), 16'h0001);

    reg_wr(1, 16'hFFFF);
    reg_wr(0, cmd(1, 1, 1, 1, 16));
    wait_idle();
    chk(!mdc && !mdio_oe, "R9 idle after write", int'({mdc, mdio_oe}), 0);

    finish_run();
  end
endmodule